// File: doc/BRIEF.md
# Boundary-scan test access port with health-reporting instruction capture

This block is a test access port controller for a chip's boundary-scan path. It follows the TMS sequence on the test clock through the sixteen standard controller states. It also keeps an 8-bit instruction register and routes one of three data registers between TDI and TDO. The three data registers are a 109-cell boundary chain, a 32-bit identification register and a single bypass bit.

The instruction register does not capture a constant pattern. It captures six live health flags above a fixed `01` pair. A host that runs any instruction scan therefore reads the controller's error and done status in the same pass. The decoded instructions are boundary test, sample/preload, identification and bypass. Every other opcode falls back to bypass.

The boundary chain has parallel capture inputs and parallel update outputs. Those outputs change only under the two boundary instructions. Pad drivers are not part of this block.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low at a rising TCK edge, the controller enters Test-Logic-Reset and the active instruction becomes 8'h09 (identification). After the release, `tdo_oe` and `tdo` are low, and a data scan returns the identification value.
- R2: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. This also restores 8'h09 as the active instruction.
- R3: On the edge that leaves Capture-IR, the instruction shift register loads `{health[5:0], 2'b01}`. The bits of `health` are: bit 5 instruction error, bit 4 configuration failed, bit 3 read error, bit 2 card error, bit 1 configuration error, bit 0 configuration done.
- R4: In Shift-IR, TDO presents the instruction shift register least significant bit first, and TDI enters at bit 7. Only Update-IR and Test-Logic-Reset change the active instruction.
- R5: The opcodes are 8'h00 boundary test, 8'h01 sample/preload, 8'h09 identification and 8'hFF bypass. Any other value selects the bypass bit. `ext_mode` is high only while 8'h00 is active.
- R6: The bypass register is one bit. It captures 0 in Capture-DR and delays TDI by one shift.
- R7: Under 8'h09, the 32-bit identification register captures the `IDCODE` parameter (bit 0 = 1) and shifts it out least significant bit first.
- R8: Under 8'h00 or 8'h01, the 109-cell chain captures `bsr_cap` in Capture-DR. It shifts bit 0 out on TDO and takes TDI in at bit 108.
- R9: Update-DR copies the chain to `bsr_upd` only under 8'h00 or 8'h01. Under every other opcode, `bsr_upd` is unchanged.
- R10: TDO changes only on the falling edge of TCK. It holds its value across the rising edge that shifts the registers.
- R11: `tdo_oe` is high exactly during Shift-IR and Shift-DR, updated on the falling edge. `tdo` is low whenever `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising TCK |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| health | input | 6 | Live status and error flags captured in Capture-IR |
| bsr_cap | input | 109 | Parallel capture values of the boundary cells |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| bsr_upd | output | 109 | Boundary update latches |
| ext_mode | output | 1 | High while the boundary test instruction is active |

## Verification
Two functions can meet on one TCK edge. The health flags can change on the same edge that Capture-IR samples them, and the captured bits go out while the next instruction shifts in. The bench changes `health` just before that capture edge and again just after it. It expects the shifted-out pattern to reflect only the value present at the edge. A separate check pairs the rising edge that shifts the bypass bit with the falling edge that drives TDO, and confirms that TDO holds across the first and moves on the second.

// File: rtl/scan_tap_pkg.sv
// Shared types and constants for the boundary-scan access port.
// Assumes an 8-bit instruction register; opcode values are fixed here.
package scan_tap_pkg;

    localparam int IR_LEN = 8;
    localparam int HLT_W  = IR_LEN - 2;

    localparam logic [IR_LEN-1:0] OP_EXT  = 8'h00;
    localparam logic [IR_LEN-1:0] OP_SMP  = 8'h01;
    localparam logic [IR_LEN-1:0] OP_ID   = 8'h09;
    localparam logic [IR_LEN-1:0] OP_BYP  = 8'hFF;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        SEL_BYP, SEL_BSR, SEL_IDC
    } dr_sel_t;

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state controller sequencer stepping on rising TCK from TMS.
// Assumes trst_n is synchronous to TCK; a low value forces Test-Logic-Reset.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;
    logic [2:0] hi_run;

    // Next-state decode of the standard TMS graph.
    always_comb begin
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            default:   nxt = tms ? ST_SEL_DR : ST_RTI;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // Saturating run length of consecutive TMS-high edges, for the checker below.
    always_ff @(posedge tck) begin
        if (!trst_n)        hi_run <= 3'd0;
        else if (!tms)      hi_run <= 3'd0;
        else if (hi_run < 3'd5) hi_run <= hi_run + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_run == 3'd5) |-> (state == ST_TLR)); // R2

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction register: health capture, serial shift, update and opcode decode.
// Assumes the health flags are stable around the Capture-IR edge or sampled as-is.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_t        state,
    input  logic              tdi,
    input  logic [HLT_W-1:0]  health,
    output logic              ir_so,
    output dr_sel_t           dr_sel,
    output logic              ext_mode
);

    logic [IR_LEN-1:0] ir_sr;
    logic [IR_LEN-1:0] ir_act;

    // Capture and shift path of the instruction shift register.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= '0;
        else if (state == ST_CAP_IR) ir_sr <= {health, 2'b01};
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
    end

    // Active instruction: identification after reset, shifted value on update.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_act <= OP_ID;
        else if (state == ST_TLR)    ir_act <= OP_ID;
        else if (state == ST_UPD_IR) ir_act <= ir_sr;
    end

    // Opcode decode; unknown values fall back to bypass.
    always_comb begin
        case (ir_act)
            OP_EXT, OP_SMP: dr_sel = SEL_BSR;
            OP_ID:          dr_sel = SEL_IDC;
            default:        dr_sel = SEL_BYP;
        endcase
    end

    assign ext_mode = (ir_act == OP_EXT);
    assign ir_so    = ir_sr[0];

    AST_CAPTURE_HEALTH: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == {$past(health), 2'b01})); // R3
    AST_INSTR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_act)); // R4

endmodule

// File: rtl/scan_tap_dr.sv
// Data registers: boundary chain with update latches, identification and bypass.
// Assumes dr_sel is stable throughout a data scan (it changes only in IR states).
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter int          ID_LEN  = 32,
    parameter logic [31:0] IDCODE  = 32'h4B71_D0C3
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_t         state,
    input  dr_sel_t            dr_sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bsr_cap,
    output logic [BSR_LEN-1:0] bsr_upd,
    output logic               dr_so
);

    localparam logic [ID_LEN-1:0] ID_VAL = IDCODE[ID_LEN-1:0];

    logic [BSR_LEN-1:0] bsr_sr;
    logic [ID_LEN-1:0]  id_sr;
    logic               byp_q;

    // Capture and shift of whichever data register the instruction selects.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            bsr_sr <= '0;
            id_sr  <= '0;
            byp_q  <= 1'b0;
        end else if (state == ST_CAP_DR) begin
            case (dr_sel)
                SEL_BSR: bsr_sr <= bsr_cap;
                SEL_IDC: id_sr  <= ID_VAL;
                default: byp_q  <= 1'b0;
            endcase
        end else if (state == ST_SH_DR) begin
            case (dr_sel)
                SEL_BSR: bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
                SEL_IDC: id_sr  <= {tdi, id_sr[ID_LEN-1:1]};
                default: byp_q  <= tdi;
            endcase
        end
    end

    // Update latches follow the chain only under the boundary instructions.
    always_ff @(posedge tck) begin
        if (!trst_n)                                       bsr_upd <= '0;
        else if (state == ST_UPD_DR && dr_sel == SEL_BSR)  bsr_upd <= bsr_sr;
    end

    // Serial output mux.
    always_comb begin
        case (dr_sel)
            SEL_BSR: dr_so = bsr_sr[0];
            SEL_IDC: dr_so = id_sr[0];
            default: dr_so = byp_q;
        endcase
    end

    AST_UPD_GUARDED: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_UPD_DR && dr_sel == SEL_BSR) |=> $stable(bsr_upd)); // R9
    AST_BYP_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && dr_sel == SEL_BYP) |=> !byp_q); // R6

endmodule

// File: rtl/scan_tap.sv
// Top of the boundary-scan access port: sequencer, instruction and data registers,
// and the falling-edge TDO stage. Assumes TDO is sampled by the host on rising TCK.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter int          ID_LEN  = 32,
    parameter logic [31:0] IDCODE  = 32'h4B71_D0C3
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [5:0]         health,
    input  logic [BSR_LEN-1:0] bsr_cap,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bsr_upd,
    output logic               ext_mode
);

    tap_state_t state;
    dr_sel_t    dr_sel;
    logic       ir_so;
    logic       dr_so;
    logic       in_shift;

    scan_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    scan_tap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .tdi      (tdi),
        .health   (health),
        .ir_so    (ir_so),
        .dr_sel   (dr_sel),
        .ext_mode (ext_mode)
    );

    scan_tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_LEN  (ID_LEN),
        .IDCODE  (IDCODE)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .dr_sel  (dr_sel),
        .tdi     (tdi),
        .bsr_cap (bsr_cap),
        .bsr_upd (bsr_upd),
        .dr_so   (dr_so)
    );

    assign in_shift = (state == ST_SH_IR) || (state == ST_SH_DR);

    // Falling-edge output stage: drive data and enable only while shifting.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift;
            tdo    <= in_shift ? ((state == ST_SH_IR) ? ir_so : dr_so) : 1'b0;
        end
    end

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == in_shift); // R11
    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo); // R11

endmodule

// File: tb/sim_scan_tap.sv
module sim_scan_tap;

    localparam int          BL  = 109;
    localparam logic [31:0] IDV = 32'h4B71_D0C3;
    localparam int          NSW = 40;

    logic          tck = 1'b0;
    logic          trst_n, tms, tdi;
    logic [5:0]    health;
    logic [BL-1:0] bsr_cap;
    logic          tdo, tdo_oe, ext_mode;
    logic [BL-1:0] bsr_upd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit oe_all;

    scan_tap #(.BSR_LEN(BL), .ID_LEN(32), .IDCODE(IDV)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .health(health),
        .bsr_cap(bsr_cap), .tdo(tdo), .tdo_oe(tdo_oe), .bsr_upd(bsr_upd),
        .ext_mode(ext_mode)
    );

    always #10 tck = ~tck;

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One TCK cycle: drive, sample TDO before the rising edge, settle after the falling edge.
    task automatic step(input logic t, input logic d, output logic o);
        tms = t; tdi = d; o = tdo;
        if (!tdo_oe) oe_all = 1'b0;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic scan_ir(input logic [7:0] din, output logic [7:0] dout);
        logic x;
        step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
        oe_all = 1'b1;
        for (int i = 0; i < 8; i++) step(i == 7, din[i], dout[i]);
        check("R11 oe during Shift-IR", {127'd0, oe_all}, 128'd1);
        step(1, 0, x); step(0, 0, x);
        check("R11 oe low in idle", {127'd0, tdo_oe}, 128'd0);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        logic x;
        dout = '0;
        step(1, 0, x); step(0, 0, x); step(0, 0, x);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], dout[i]);
        step(1, 0, x); step(0, 0, x);
    endtask

    function automatic logic [BL-1:0] mkpat(input int seed);
        logic [BL-1:0] p;
        for (int i = 0; i < BL; i++) p[i] = (((i * 7 + seed) % 5) < 2);
        return p;
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]   iro;
        logic [127:0] dro, exp;
        logic [BL-1:0] pat, upd_exp;
        logic [39:0]  psw;
        logic x, pre, mid;

        trst_n = 0; tms = 1; tdi = 0; health = 6'd0;
        bsr_cap = mkpat(3);
        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        trst_n = 1;
        check("R1 oe after reset", {127'd0, tdo_oe}, 128'd0);
        check("R1 tdo after reset", {127'd0, tdo}, 128'd0);
        check("R1 bsr_upd after reset", {19'd0, bsr_upd}, 128'd0);
        step(0, 0, x);
        scan_dr(32, 128'd0, dro);
        check("R1 R7 identification after reset", dro, {96'd0, IDV});

        // R3: exhaustive sweep of the health flags through Capture-IR.
        for (int h = 0; h < 64; h++) begin
            health = h[5:0];
            scan_ir(8'hFF, iro);
            check("R3 captured health pattern", {120'd0, iro}, {120'd0, h[5:0], 2'b01});
        end

        // R3: flags move right before and right after the capture edge.
        health = 6'h2A;
        step(1, 0, x); step(1, 0, x); step(0, 0, x);
        health = 6'h15;
        step(0, 0, x);
        health = 6'h3F;
        for (int i = 0; i < 8; i++) step(i == 7, 1'b0, iro[i]);
        step(1, 0, x); step(0, 0, x);
        check("R3 capture edge value", {120'd0, iro}, {120'd0, 6'h15, 2'b01});
        check("R4 zeros shifted in select EXTEST", {127'd0, ext_mode}, 128'd1);

        // R10: bypass bit, TDO holds across the rising edge and moves on the falling edge.
        health = 6'd0;
        scan_ir(8'hFF, iro);
        step(1, 0, x); step(0, 0, x); step(0, 0, x);
        tms = 0; tdi = 1; pre = tdo;
        @(posedge tck); #1; mid = tdo;
        @(negedge tck); #1;
        check("R10 R6 tdo before edge", {127'd0, pre}, 128'd0);
        check("R10 tdo held over rising edge", {127'd0, mid}, 128'd0);
        check("R10 R6 tdo after falling edge", {127'd0, tdo}, 128'd1);
        // R2: five TMS-high edges from Shift-DR restore the identification instruction.
        for (int i = 0; i < 5; i++) step(1, 0, x);
        step(0, 0, x);
        scan_dr(32, 128'd0, dro);
        check("R2 identification after five TMS high", dro, {96'd0, IDV});

        // R8 R9: full sample/preload chain.
        pat = mkpat(1);
        scan_ir(8'h01, iro);
        check("R5 sample/preload not EXTEST", {127'd0, ext_mode}, 128'd0);
        scan_dr(BL, {19'd0, pat}, dro);
        check("R8 captured chain", dro, {19'd0, bsr_cap});
        check("R9 update under sample/preload", {19'd0, bsr_upd}, {19'd0, pat});
        upd_exp = pat;

        // R5 R6 R7 R8 R9: sweep of every opcode with a short data scan.
        psw = 40'hC3_5A96_1E7B;
        for (int op = 0; op < 256; op++) begin
            scan_ir(op[7:0], iro);
            scan_dr(NSW, {88'd0, psw}, dro);
            if (op == 0 || op == 1) begin
                exp = {88'd0, bsr_cap[39:0]};
                upd_exp = {psw, bsr_cap[BL-1:40]};
            end else if (op == 9) begin
                exp = {88'd0, psw[7:0], IDV};
            end else begin
                exp = {88'd0, psw[38:0], 1'b0};
            end
            check("R5 R6 R7 R8 opcode data path", dro, exp);
            check("R9 update latches", {19'd0, bsr_upd}, {19'd0, upd_exp});
            check("R5 ext_mode decode", {127'd0, ext_mode}, {127'd0, op == 0});
        end

        // R4: the instruction survives data scans.
        scan_ir(8'h00, iro);
        scan_dr(NSW, 128'd0, dro);
        scan_dr(NSW, 128'd0, dro);
        check("R4 instruction held", {127'd0, ext_mode}, 128'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule